// File: doc/BRIEF.md
# I2C Bus Slave with Clock-Line Glitch Filter

This block is a slave-only I2C port that sits behind a small CPU register file. Software writes a 7-bit station address and sets an enable bit. The block then follows the two bus lines through synchronisers and a debounce stage, and detects START and STOP conditions. After each START it compares the first seven received bits against the stored address. If they match, it acknowledges and carries out byte transfers in the direction that the eighth bit requests. Both lines are driven open-drain: the block only asserts an output-enable that pulls the line low, and the outside pull-ups supply the high level.

Every byte in either direction passes through one data register. When a byte completes, the block raises a single-cycle interrupt and holds SCL low. It lets SCL go only when software reads or writes the data register. This gives software time to collect a received byte or to supply the next byte to send. A separate pin-level enable input models the case where the pins are assigned to another function. While that input is low, the block stays off the bus.

Top module: `i2cs_core`

## Requirements
- R1: After reset, both output-enables and `irq` are low. Control (offset 0), status (offset 1), address (offset 2) and data (offset 3) all read back as 0x00.
- R2: The port is active only when control bit 0 is 1 and `mux_en` is high. Otherwise it drives neither line, raises no interrupt and acknowledges no address.
- R3: The 7 address bits received after a START, MSB first, are compared with address-register bits 7:1. Bit 0 is stored but has no effect. On a match the slave pulls SDA low during the ninth clock. On a mismatch it leaves SDA released and stays off the bus until the next START.
- R4: The eighth address bit sets the direction: 1 means the slave transmits and 0 means it receives. Status bit 1 shows the direction and status bit 0 shows that the slave is selected.
- R5: In receive mode, each data byte is shifted in MSB first, stored in the data register at the end of the eighth clock, and acknowledged in the ninth clock.
- R6: In transmit mode, the data-register byte is sent MSB first, and SDA changes only while SCL is low.
- R7: In transmit mode, the master's ninth-clock bit is sampled. A high level (NACK) sets status bit 2, releases both lines and starts no clock hold.
- R8: Each completed byte (address or data) gives a one-cycle `irq` pulse. Unless a NACK ended it, SCL is also held low from that cycle, with status bit 3 set, until the data register is read or written.
- R9: A STOP (SDA rising while SCL is high) returns the slave to idle, clears status bit 0 and releases SDA. A START received while the slave is selected restarts the address phase.
- R10: With `dbnc_sel` = 1, a line level must hold for 2 system clocks before it is accepted, so a single-clock SCL pulse is ignored. With `dbnc_sel` = 0, one clock is enough and such a pulse counts as a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mux_en | input | 1 | Pins assigned to this port |
| dbnc_sel | input | 1 | Debounce length: 0 = one clock, 1 = two clocks |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after `bus_rd` |
| irq | output | 1 | One-cycle pulse per completed byte |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
The hardest case to reach from the ports is a one-clock pulse on SCL that arrives in the middle of an address byte. It must be swallowed when the two-clock debounce is selected and counted as an extra edge when the one-clock setting is chosen. The bench's open-drain bus model drives exactly one such pulse, aligned to a single sampling edge, after the first address bit. It sends the same address under both settings and expects an ACK in the first case and a NACK in the second, because the extra edge misaligns the bits. Repeated START while selected and a master NACK on a transmitted byte are reached in the same way, through scripted master sequences that read the line levels back.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_STAT = 2'd1;
  localparam logic [1:0] OFS_OWN  = 2'd2;
  localparam logic [1:0] OFS_DATA = 2'd3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RXB,
    ST_RACK,
    ST_TXB,
    ST_TACK,
    ST_HOLD,
    ST_SKIP
  } eng_st_t;

  typedef struct packed {
    logic rise;
    logic fall;
    logic start;
    logic stop;
  } bus_ev_t;

endpackage

// File: rtl/i2cs_filt.sv
module i2cs_filt #(
  parameter int SYNC_STAGES = 2,
  parameter int DB_SHORT    = 1,
  parameter int DB_LONG     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic two,
  output logic clean
);
  localparam int CW = $clog2(DB_LONG + 1);
  localparam logic [CW-1:0] LIM_S = CW'(DB_SHORT - 1);
  localparam logic [CW-1:0] LIM_L = CW'(DB_LONG - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt;
  logic [CW-1:0]          lim;
  logic                   smp;

  assign smp = sync_q[SYNC_STAGES-1];
  assign lim = two ? LIM_L : LIM_S;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
  end

  // R10: level accepted only after it differs from the output for lim+1 clocks
  always_ff @(posedge clk) begin
    if (rst) begin
      clean <= 1'b1;
      cnt   <= '0;
    end else if (smp != clean) begin
      if (cnt >= lim) begin
        clean <= smp;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond
  import i2cs_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    scl_f,
  input  logic    sda_f,
  output bus_ev_t ev
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  // R9: conditions judged on filtered lines while SCL stays high
  assign ev.rise  = scl_f & ~scl_p;
  assign ev.fall  = ~scl_f & scl_p;
  assign ev.start = scl_f & scl_p & sda_p & ~sda_f;
  assign ev.stop  = scl_f & scl_p & ~sda_p & sda_f;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  bus_ev_t       ev,
  input  logic          sda_f,
  input  logic [DW-1:1] own_addr,
  input  logic          dat_wr,
  input  logic          dat_rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] data_q,
  output logic          sel,
  output logic          dir_tx,
  output logic          nack,
  output logic          hold,
  output logic          sda_oe,
  output logic          irq
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST_RX = CW'(DW);
  localparam logic [CW-1:0] LAST_TX = CW'(DW - 1);

  eng_st_t       st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;
  logic [DW-1:0] tx_src;
  logic          dat_acc;
  logic          rx_done;

  assign dat_acc = dat_wr | dat_rd;
  assign tx_src  = dat_wr ? wdata : data_q;
  assign rx_done = (st == ST_RXB) && ev.fall && (cnt == LAST_RX);

  // R5: one shared data register; a received byte takes priority over software
  always_ff @(posedge clk) begin
    if (rst)          data_q <= '0;
    else if (rx_done) data_q <= sh;
    else if (dat_wr)  data_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      sel    <= 1'b0;
      dir_tx <= 1'b0;
      nack   <= 1'b0;
      hold   <= 1'b0;
      sda_oe <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (ev.start) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sel    <= 1'b0;
        nack   <= 1'b0;
        hold   <= 1'b0;
        sda_oe <= 1'b0;
      end else if (ev.stop) begin
        st     <= ST_IDLE;
        sel    <= 1'b0;
        hold   <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: begin
            if (ev.rise) begin
              sh  <= {sh[DW-2:0], sda_f};
              cnt <= cnt + 1'b1;
            end else if (ev.fall && cnt == LAST_RX) begin
              // R3: bit 0 of the stored address plays no part
              if (sh[DW-1:1] == own_addr) begin
                sel    <= 1'b1;
                dir_tx <= sh[0];
                sda_oe <= 1'b1;
                st     <= ST_AACK;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          ST_AACK, ST_RACK: begin
            if (ev.fall) begin
              sda_oe <= 1'b0;
              hold   <= 1'b1;
              irq    <= 1'b1;
              st     <= ST_HOLD;
            end
          end
          ST_HOLD: begin
            // R8: clock held until the data register is touched
            if (dat_acc) begin
              hold <= 1'b0;
              cnt  <= '0;
              if (dir_tx) begin
                sh     <= tx_src;
                sda_oe <= ~tx_src[DW-1];
                st     <= ST_TXB;
              end else begin
                st <= ST_RXB;
              end
            end
          end
          ST_RXB: begin
            if (ev.rise) begin
              sh  <= {sh[DW-2:0], sda_f};
              cnt <= cnt + 1'b1;
            end else if (rx_done) begin
              sda_oe <= 1'b1;
              st     <= ST_RACK;
            end
          end
          ST_TXB: begin
            // R6: next bit placed only on a falling SCL
            if (ev.fall) begin
              if (cnt == LAST_TX) begin
                sda_oe <= 1'b0;
                st     <= ST_TACK;
              end else begin
                cnt    <= cnt + 1'b1;
                sh     <= {sh[DW-2:0], 1'b0};
                sda_oe <= ~sh[DW-2];
              end
            end
          end
          ST_TACK: begin
            if (ev.rise) begin
              nack <= sda_f;
            end else if (ev.fall) begin
              irq <= 1'b1;
              if (nack) begin
                st <= ST_SKIP;
              end else begin
                hold <= 1'b1;
                st   <= ST_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cs_core.sv
module i2cs_core
  import i2cs_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DB_SHORT    = 1,
  parameter int DB_LONG     = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mux_en,
  input  logic          dbnc_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] raw_w;
  logic [NLINE-1:0] flt_w;
  logic             ctrl_on;
  logic [DW-1:0]    own_q;
  logic [DW-1:0]    data_w;
  logic [DW-1:0]    stat_w;
  logic             en_w, sel_w, dir_w, nack_w, hold_w;
  logic             dat_wr, dat_rd;
  bus_ev_t          ev_w;

  assign raw_w = {sda_i, scl_i};

  // Both lines get the same delay so their relative timing is preserved
  for (genvar g = 0; g < NLINE; g++) begin : g_line
    i2cs_filt #(
      .SYNC_STAGES(SYNC_STAGES),
      .DB_SHORT   (DB_SHORT),
      .DB_LONG    (DB_LONG)
    ) u_filt (
      .clk  (clk),
      .rst  (rst),
      .raw  (raw_w[g]),
      .two  (dbnc_sel),
      .clean(flt_w[g])
    );
  end

  i2cs_cond u_cond (
    .clk  (clk),
    .rst  (rst),
    .scl_f(flt_w[0]),
    .sda_f(flt_w[1]),
    .ev   (ev_w)
  );

  // R2: both the control bit and the pin assignment must be on
  assign en_w   = ctrl_on & mux_en;
  assign dat_wr = bus_wr && bus_addr == OFS_DATA;
  assign dat_rd = bus_rd && bus_addr == OFS_DATA;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_on <= 1'b0;
      own_q   <= '0;
    end else if (bus_wr) begin
      if (bus_addr == OFS_CTRL) ctrl_on <= bus_wdata[0];
      if (bus_addr == OFS_OWN)  own_q   <= bus_wdata;
    end
  end

  i2cs_engine #(.DW(DW)) u_eng (
    .clk     (clk),
    .rst     (rst),
    .en      (en_w),
    .ev      (ev_w),
    .sda_f   (flt_w[1]),
    .own_addr(own_q[DW-1:1]),
    .dat_wr  (dat_wr),
    .dat_rd  (dat_rd),
    .wdata   (bus_wdata),
    .data_q  (data_w),
    .sel     (sel_w),
    .dir_tx  (dir_w),
    .nack    (nack_w),
    .hold    (hold_w),
    .sda_oe  (sda_oe),
    .irq     (irq)
  );

  assign scl_oe = hold_w;
  assign stat_w = {{(DW-4){1'b0}}, hold_w, nack_w, dir_w, sel_w};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (bus_addr)
        OFS_CTRL: bus_rdata <= {{(DW-1){1'b0}}, ctrl_on};
        OFS_STAT: bus_rdata <= stat_w;
        OFS_OWN:  bus_rdata <= own_q;
        default:  bus_rdata <= data_w;
      endcase
    end
  end
endmodule

// File: rtl/i2cs_core_chk.sv
module i2cs_core_chk
  import i2cs_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       mux_en,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [1:0] bus_addr,
  input logic       irq,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       sel
);
  logic dat_touch;
  logic ctrl_touch;
  assign dat_touch  = (bus_wr || bus_rd) && bus_addr == OFS_DATA;
  assign ctrl_touch = bus_wr && bus_addr == OFS_CTRL;

  // R1
  a_r1_released_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!scl_oe && !sda_oe && !irq));

  // R2
  a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !mux_en |=> (!scl_oe && !sda_oe && !irq));

  // R3
  a_r3_drive_only_selected: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> sel);

  // R8
  a_r8_irq_one_cycle: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R8
  a_r8_stretch_with_irq: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_oe) |-> irq);

  // R8
  a_r8_hold_until_access: assert property (@(posedge clk) disable iff (rst)
    (scl_oe && mux_en && !dat_touch && !ctrl_touch) |=> scl_oe);
endmodule

bind i2cs_core i2cs_core_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .mux_en  (mux_en),
  .bus_wr  (bus_wr),
  .bus_rd  (bus_rd),
  .bus_addr(bus_addr),
  .irq     (irq),
  .scl_oe  (scl_oe),
  .sda_oe  (sda_oe),
  .sel     (sel_w)
);

// File: tb/i2cs_core_tb_top.sv
`timescale 1ns/1ps
module i2cs_core_tb_top;
  localparam int HT  = 16;
  localparam int WDG = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mux_en = 1'b1;
  logic       dbnc_sel = 1'b1;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq, scl_oe, sda_oe;
  logic       m_scl_low = 1'b0;
  logic       m_sda_low = 1'b0;
  logic       scl_line, sda_line;

  assign scl_line = !(m_scl_low || scl_oe);
  assign sda_line = !(m_sda_low || sda_oe);

  always #2.5 clk = ~clk;

  i2cs_core dut_i (
    .clk(clk), .rst(rst), .mux_en(mux_en), .dbnc_sel(dbnc_sel),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int n_chk = 0;
  int n_bad = 0;
  int irq_cnt = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  string      tag_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pairs produced bytes with expected ones
  initial forever begin
    @(negedge clk);
    if (irq) irq_cnt++;
    while (got_q.size() > 0 && exp_q.size() > 0) begin
      automatic logic [7:0] g = got_q.pop_front();
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(g == e, t, g, e);
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic m_start();
    m_sda_low = 1'b0; wt(HT);
    m_scl_low = 1'b0; wait (scl_line); wt(HT);
    m_sda_low = 1'b1; wt(HT);
    m_scl_low = 1'b1; wt(HT);
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1; wt(HT);
    m_scl_low = 1'b0; wait (scl_line); wt(HT);
    m_sda_low = 1'b0; wt(HT);
  endtask

  task automatic m_wbit(input bit b);
    m_sda_low = !b; wt(HT);
    m_scl_low = 1'b0; wait (scl_line); wt(HT);
    m_scl_low = 1'b1; wt(HT);
  endtask

  task automatic m_rbit(output bit b);
    m_sda_low = 1'b0; wt(HT);
    m_scl_low = 1'b0; wait (scl_line); wt(HT/2);
    b = sda_line; wt(HT/2);
    m_scl_low = 1'b1; wt(HT);
  endtask

  // glitch_on: inject a one-clock SCL high pulse after the first bit
  task automatic m_wbyte(input logic [7:0] d, input bit glitch_on, output bit nak);
    for (int i = 7; i >= 0; i--) begin
      m_wbit(d[i]);
      if (glitch_on && i == 7) begin
        @(negedge clk) m_scl_low = 1'b0;
        @(negedge clk) m_scl_low = 1'b1;
        wt(HT);
      end
    end
    m_rbit(nak);
  endtask

  task automatic m_rbyte(input bit give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      bit b;
      m_rbit(b);
      d[i] = b;
    end
    m_wbit(!give_ack);
    m_sda_low = 1'b0;
  endtask

  task automatic rx_byte(input logic [7:0] d, input string t);
    bit nak;
    logic [7:0] r;
    exp_q.push_back(d); tag_q.push_back(t);
    m_wbyte(d, 1'b0, nak);
    check(nak == 1'b0, {t, " ack"}, nak, 0);
    check(scl_oe == 1'b1, "R8 hold after rx byte", scl_oe, 1);
    cpu_rd(2'd3, r);
    got_q.push_back(r);
    wt(2);
    check(scl_oe == 1'b0, "R8 released by data read", scl_oe, 0);
  endtask

  initial begin
    logic [7:0] v;
    bit nak;
    int ic;
    wt(4);
    rst = 1'b0;
    wt(2);
    // R1 reset state
    check(!scl_oe && !sda_oe && !irq, "R1 lines", {scl_oe, sda_oe, irq}, 0);
    for (int a = 0; a < 4; a++) begin
      cpu_rd(a[1:0], v);
      check(v == 8'h00, "R1 register", v, 0);
    end

    cpu_wr(2'd2, 8'h55);           // address 0x2A, bit 0 set and ignored (R3)
    cpu_wr(2'd0, 8'h01);
    cpu_rd(2'd2, v);
    check(v == 8'h55, "R3 address readback", v, 8'h55);
    cpu_rd(2'd0, v);
    check(v == 8'h01, "R2 control readback", v, 1);

    // receive transfer
    ic = irq_cnt;
    m_start();
    m_wbyte(8'h54, 1'b0, nak);
    check(nak == 1'b0, "R3 address ack", nak, 0);
    check(irq_cnt == ic + 1, "R8 irq after address", irq_cnt - ic, 1);
    cpu_rd(2'd1, v);
    check(v == 8'h09, "R4 status write-direction", v, 8'h09);
    cpu_rd(2'd3, v);
    rx_byte(8'hA5, "R5 rx byte 0");
    rx_byte(8'h3C, "R5 rx byte 1");
    check(irq_cnt == ic + 3, "R8 irq per byte", irq_cnt - ic, 3);
    m_stop();
    cpu_rd(2'd1, v);
    check(v == 8'h00, "R9 stop clears selected", v, 0);

    // transmit transfer
    m_start();
    m_wbyte(8'h55, 1'b0, nak);
    check(nak == 1'b0, "R3 read address ack", nak, 0);
    cpu_rd(2'd1, v);
    check(v == 8'h0B, "R4 status read-direction", v, 8'h0B);
    exp_q.push_back(8'h96); tag_q.push_back("R6 tx byte 0");
    cpu_wr(2'd3, 8'h96);
    m_rbyte(1'b1, v);
    got_q.push_back(v);
    check(scl_oe == 1'b1, "R8 hold after acked tx", scl_oe, 1);
    exp_q.push_back(8'h0F); tag_q.push_back("R6 tx byte 1");
    ic = irq_cnt;
    cpu_wr(2'd3, 8'h0F);
    m_rbyte(1'b0, v);
    got_q.push_back(v);
    check(irq_cnt == ic + 1, "R8 irq on nacked byte", irq_cnt - ic, 1);
    check(scl_oe == 1'b0 && sda_oe == 1'b0, "R7 released after nack", {scl_oe, sda_oe}, 0);
    cpu_rd(2'd1, v);
    check(v == 8'h07, "R7 status nack", v, 8'h07);
    m_stop();
    cpu_rd(2'd1, v);
    check(v == 8'h06, "R9 stop after tx", v, 8'h06);

    // address mismatch
    ic = irq_cnt;
    m_start();
    m_wbyte(8'h56, 1'b0, nak);
    check(nak == 1'b1, "R3 mismatch no ack", nak, 1);
    check(irq_cnt == ic, "R3 mismatch no irq", irq_cnt - ic, 0);
    m_stop();

    // repeated start while selected
    m_start();
    m_wbyte(8'h54, 1'b0, nak);
    check(nak == 1'b0, "R9 first address ack", nak, 0);
    cpu_rd(2'd3, v);
    rx_byte(8'h11, "R5 rx before restart");
    m_start();
    m_wbyte(8'h55, 1'b0, nak);
    check(nak == 1'b0, "R9 restart address ack", nak, 0);
    cpu_rd(2'd1, v);
    check(v == 8'h0B, "R9 restart direction", v, 8'h0B);
    exp_q.push_back(8'h5A); tag_q.push_back("R6 tx after restart");
    cpu_wr(2'd3, 8'h5A);
    m_rbyte(1'b0, v);
    got_q.push_back(v);
    m_stop();

    // pins assigned elsewhere
    mux_en = 1'b0;
    ic = irq_cnt;
    m_start();
    m_wbyte(8'h54, 1'b0, nak);
    check(nak == 1'b1, "R2 no ack when off", nak, 1);
    check(irq_cnt == ic && !scl_oe, "R2 no irq or hold when off", irq_cnt - ic, 0);
    m_stop();
    mux_en = 1'b1;
    wt(4);

    // control bit off
    cpu_wr(2'd0, 8'h00);
    m_start();
    m_wbyte(8'h54, 1'b0, nak);
    check(nak == 1'b1, "R2 no ack with control off", nak, 1);
    m_stop();
    cpu_wr(2'd0, 8'h01);

    // debounce: two-clock setting rejects the pulse
    dbnc_sel = 1'b1;
    m_start();
    m_wbyte(8'h54, 1'b1, nak);
    check(nak == 1'b0, "R10 pulse rejected, ack", nak, 0);
    cpu_rd(2'd3, v);
    m_stop();
    // one-clock setting counts it as an edge and misaligns the address
    dbnc_sel = 1'b0;
    ic = irq_cnt;
    m_start();
    m_wbyte(8'h54, 1'b1, nak);
    check(nak == 1'b1, "R10 pulse accepted, nack", nak, 1);
    check(irq_cnt == ic, "R10 no irq on misaligned address", irq_cnt - ic, 0);
    m_stop();

    wt(4);
    check(exp_q.size() == 0 && got_q.size() == 0, "R5 scoreboard drained",
          exp_q.size() + got_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (WDG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0x%0h expected=0x%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule